// File: doc/BRIEF.md
# Bit-Vector Auto-Correlation Counter Array

This block keeps a running auto-correlation matrix of a vector of antipodal bits. Each bit is encoded on one wire, with 1 standing for +1 and 0 standing for -1. The matrix is square, with 2K rows and 2K columns, where K is the user count. On every update strobe it adds the outer product of the current bit vector to the matrix. The product of two bits is their XNOR, so no multiplier is needed. Each matrix element is a signed saturating up/down counter that moves by the sign of that product.

The matrix is symmetric, so only the upper triangle and the diagonal are stored. A read of element (i,j) with i greater than j returns element (j,i). The diagonal gains +1 on every plain update, because a bit multiplied by itself is always +1.

In tracking mode the outer product of a second, older bit vector is taken away in the same cycle. A sliding window over detected bits therefore costs one strobe per step. A synchronous clear zeroes the whole matrix. All elements are updated in parallel, in one clock.

Top module: `acm_xnor_corr`

## Requirements
- R1: After reset is released, every element (i,j) reads 0.
- R2: On an update strobe with tracking off, an element with i<j changes by +1 when bits i and j of `bits_cur` are equal, and by -1 when they differ. Bit value 1 means +1 and bit value 0 means -1.
- R3: On an update strobe with tracking off, every diagonal element increases by 1.
- R4: On an update strobe with tracking on, an element with i<j changes by (new - old), which is always one of -2, 0 or +2. Here new is +1 if bits i and j of `bits_cur` are equal and -1 otherwise, and old is formed the same way from `bits_prev`.
- R5: On an update strobe with tracking on, the diagonal elements hold their value.
- R6: The elements saturate at +127 and -128 (for the default 8-bit width) and never wrap.
- R7: `clr` zeroes all elements at the next clock edge. It takes priority over a simultaneous update strobe.
- R8: While neither `upd` nor `clr` is high, no element changes, whatever `bits_cur`, `bits_prev` and `track` do.
- R9: The read port is combinational. A read of (i,j) with i>j returns the same value as a read of (j,i).
- R10: A single strobe updates every element of the matrix in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all elements |
| upd | input | 1 | Update strobe |
| track | input | 1 | When high, an update also subtracts the outer product of `bits_prev` |
| bits_cur | input | 2K | Current bit vector (1 = +1, 0 = -1) |
| bits_prev | input | 2K | Previous bit vector, used only when tracking |
| rd_i | input | clog2(2K) | Read row index |
| rd_j | input | clog2(2K) | Read column index |
| rd_data | output | 8 | Signed element (i,j) |

## Verification
The bench first uses directed vectors: one mix of equal and unequal bit pairs, then a tracking step whose old and new products agree on some pairs and disagree on others. Together these separate the +1/-1 steps from the -2/0/+2 steps, and the diagonal's +1 from its hold. Random vectors with random tracking follow. After each of them the full matrix is read, both triangles included, which exposes a wrong pair index, a broken mirror, or an element left out of the parallel update. Long runs of all-ones vectors and of a single set bit drive elements into both limits, and one tracking step is applied at the top limit. Idle cycles with moving inputs, and a clear asserted together with a strobe, show that the inputs are ignored without a strobe and that clear wins.

// File: rtl/acm_pkg.sv
package acm_pkg;
  // Position of pair (lo,hi), lo<hi, in the flattened upper triangle of an n x n matrix
  function automatic int pair_index(int lo, int hi, int n);
    return lo * n - (lo * (lo + 1)) / 2 + (hi - lo - 1);
  endfunction
endpackage

// File: rtl/acm_cell.sv
module acm_cell #(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                upd,
  input  logic                track,
  input  logic                cur_a,
  input  logic                cur_b,
  input  logic                prev_a,
  input  logic                prev_b,
  output logic signed [W-1:0] q
);
  localparam logic signed [W+1:0] MAXV = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [W+1:0] MINV = {3'b111, {(W-1){1'b0}}};

  logic              new_pos, old_pos, en;
  logic signed [2:0] s_new, s_old, delta;
  logic signed [W+1:0] sum;
  logic signed [W-1:0] q_d;

  always_comb begin
    new_pos = ~(cur_a ^ cur_b);
    old_pos = ~(prev_a ^ prev_b);
    s_new   = new_pos ? 3'sd1 : -3'sd1;
    s_old   = track ? (old_pos ? 3'sd1 : -3'sd1) : 3'sd0;
    delta   = s_new - s_old;
    sum     = {{2{q[W-1]}}, q} + {{(W-1){delta[2]}}, delta};
    en      = clr | upd;
    if (clr)              q_d = '0;
    else if (sum > MAXV)  q_d = MAXV[W-1:0];
    else if (sum < MINV)  q_d = MINV[W-1:0];
    else                  q_d = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_d;
  end
endmodule

// File: rtl/acm_read.sv
module acm_read #(
  parameter int NB = 8,
  parameter int W  = 8,
  parameter int NP = NB * (NB - 1) / 2,
  parameter int IW = $clog2(NB)
) (
  input  logic [NB*W-1:0]     diag_flat,
  input  logic [NP*W-1:0]     pair_flat,
  input  logic [IW-1:0]       rd_i,
  input  logic [IW-1:0]       rd_j,
  output logic signed [W-1:0] rd_data
);
  int lo, hi;

  always_comb begin
    if (rd_i <= rd_j) begin
      lo = int'(rd_i);
      hi = int'(rd_j);
    end else begin
      lo = int'(rd_j);
      hi = int'(rd_i);
    end
    rd_data = '0;
    if (hi < NB) begin
      if (lo == hi) rd_data = diag_flat[lo*W +: W];
      else          rd_data = pair_flat[acm_pkg::pair_index(lo, hi, NB)*W +: W];
    end
  end
endmodule

// File: rtl/acm_xnor_corr.sv
module acm_xnor_corr #(
  parameter int NUM_USERS = 4,
  parameter int CNT_W     = 8,
  localparam int NB = 2 * NUM_USERS,
  localparam int IW = $clog2(NB)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    upd,
  input  logic                    track,
  input  logic [NB-1:0]           bits_cur,
  input  logic [NB-1:0]           bits_prev,
  input  logic [IW-1:0]           rd_i,
  input  logic [IW-1:0]           rd_j,
  output logic signed [CNT_W-1:0] rd_data
);
  localparam int NP = NB * (NB - 1) / 2;

  logic [NB*CNT_W-1:0] diag_flat;
  logic [NP*CNT_W-1:0] pair_flat;

  // Diagonal: XNOR of a bit with itself is constant 1, so these always step +1 (0 when tracking)
  for (genvar gd = 0; gd < NB; gd++) begin : g_diag
    acm_cell #(.W(CNT_W)) u_cell (
      .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd), .track(track),
      .cur_a(bits_cur[gd]), .cur_b(bits_cur[gd]),
      .prev_a(bits_prev[gd]), .prev_b(bits_prev[gd]),
      .q(diag_flat[gd*CNT_W +: CNT_W])
    );
  end

  // Upper triangle only: the lower half is served by mirroring at the read port
  for (genvar gi = 0; gi < NB; gi++) begin : g_row
    for (genvar gj = gi + 1; gj < NB; gj++) begin : g_col
      localparam int P = acm_pkg::pair_index(gi, gj, NB);
      acm_cell #(.W(CNT_W)) u_cell (
        .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd), .track(track),
        .cur_a(bits_cur[gi]), .cur_b(bits_cur[gj]),
        .prev_a(bits_prev[gi]), .prev_b(bits_prev[gj]),
        .q(pair_flat[P*CNT_W +: CNT_W])
      );
    end
  end

  acm_read #(.NB(NB), .W(CNT_W), .NP(NP), .IW(IW)) u_read (
    .diag_flat(diag_flat), .pair_flat(pair_flat),
    .rd_i(rd_i), .rd_j(rd_j), .rd_data(rd_data)
  );
endmodule

// File: rtl/acm_xnor_corr_chk.sv
module acm_xnor_corr_chk #(
  parameter int NUM_USERS = 4,
  parameter int CNT_W     = 8,
  localparam int NB = 2 * NUM_USERS,
  localparam int IW = $clog2(NB)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr,
  input logic                    upd,
  input logic                    track,
  input logic [IW-1:0]           rd_i,
  input logic [IW-1:0]           rd_j,
  input logic signed [CNT_W-1:0] rd_data
);
  localparam logic signed [CNT_W-1:0] TOP = {1'b0, {(CNT_W-1){1'b1}}};

  logic signed [CNT_W-1:0] last_rd;
  logic signed [CNT_W+1:0] diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_rd <= '0;
    else        last_rd <= rd_data;
  end

  assign diff = {{2{rd_data[CNT_W-1]}}, rd_data} - {{2{last_rd[CNT_W-1]}}, last_rd};

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rd_data == '0));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !clr) |=> (!$stable(rd_i) || !$stable(rd_j) || $stable(rd_data)));

  assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr) |=> (!$stable(rd_i) || !$stable(rd_j) || (diff >= -2 && diff <= 2)));

  assert_diag_track_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr && track && rd_i == rd_j) |=> (!$stable(rd_i) || !$stable(rd_j) || $stable(rd_data)));

  assert_diag_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr && !track && rd_i == rd_j && int'(rd_i) < NB && rd_data != TOP)
    |=> (!$stable(rd_i) || !$stable(rd_j) || diff == 1));

  assert_diag_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr && rd_i == rd_j && rd_data == TOP) |=> (!$stable(rd_i) || !$stable(rd_j) || rd_data == TOP));
endmodule

bind acm_xnor_corr acm_xnor_corr_chk #(.NUM_USERS(NUM_USERS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd), .track(track),
  .rd_i(rd_i), .rd_j(rd_j), .rd_data(rd_data)
);

// File: tb/sim_acm_xnor_corr.sv
`timescale 1ns/1ps
module sim_acm_xnor_corr;
  localparam int K  = 4;
  localparam int W  = 8;
  localparam int NB = 2 * K;
  localparam int IW = $clog2(NB);

  logic clk, rst_n, clr, upd, track;
  logic [NB-1:0] bits_cur, bits_prev;
  logic [IW-1:0] rd_i, rd_j;
  logic signed [W-1:0] rd_data;

  int ref_m[NB][NB];
  int n_checks, n_err;
  bit done;

  acm_xnor_corr #(.NUM_USERS(K), .CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd), .track(track),
    .bits_cur(bits_cur), .bits_prev(bits_prev),
    .rd_i(rd_i), .rd_j(rd_j), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int sat(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int prod(logic a, logic b);
    return (a == b) ? 1 : -1;
  endfunction

  task automatic model_update(logic [NB-1:0] c, logic [NB-1:0] p, bit trk);
    for (int i = 0; i < NB; i++)
      for (int j = i; j < NB; j++)
        ref_m[i][j] = sat(ref_m[i][j] + prod(c[i], c[j]) - (trk ? prod(p[i], p[j]) : 0));
  endtask

  task automatic model_clear();
    for (int i = 0; i < NB; i++)
      for (int j = 0; j < NB; j++)
        ref_m[i][j] = 0;
  endtask

  task automatic apply(logic [NB-1:0] c, logic [NB-1:0] p, bit trk);
    @(negedge clk);
    bits_cur = c; bits_prev = p; track = trk; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    model_update(c, p, trk);
  endtask

  task automatic do_clear(bit with_upd, logic [NB-1:0] c);
    @(negedge clk);
    clr = 1'b1; upd = with_upd; bits_cur = c; track = 1'b0;
    @(negedge clk);
    clr = 1'b0; upd = 1'b0;
    model_clear();
  endtask

  task automatic check_all(string offd, string dg);
    int exp_v;
    string tag;
    for (int i = 0; i < NB; i++) begin
      for (int j = 0; j < NB; j++) begin
        rd_i = IW'(i); rd_j = IW'(j);
        #0.5;
        exp_v = (i <= j) ? ref_m[i][j] : ref_m[j][i];
        tag = (i > j) ? "R9" : ((i == j) ? dg : offd);
        n_checks++;
        if (int'(rd_data) != exp_v) begin
          n_err++;
          $display("FAIL %s element(%0d,%0d) actual %0d expected %0d", tag, i, j, int'(rd_data), exp_v);
        end
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] c, p;
    bit trk;
    n_checks = 0; n_err = 0; done = 0;
    rst_n = 1'b0; clr = 1'b0; upd = 1'b0; track = 1'b0;
    bits_cur = '0; bits_prev = '0; rd_i = '0; rd_j = '0;
    void'($urandom(32'd2718));
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check_all("R1", "R1");

    // R2/R3: mixed equal and unequal pairs
    apply(8'b1010_0110, '0, 1'b0);
    check_all("R2", "R3");
    // R4/R5: tracking step, old products agree with new on some pairs only
    apply(8'b1100_0110, 8'b1010_0110, 1'b1);
    check_all("R4", "R5");
    // R10: one strobe moves the whole matrix
    apply(8'b0111_1000, '0, 1'b0);
    check_all("R10", "R10");

    // R8: inputs move without a strobe
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      bits_cur = NB'($urandom); bits_prev = NB'($urandom); track = 1'($urandom);
    end
    check_all("R8", "R8");

    // R7: clear together with a strobe
    do_clear(1'b1, '1);
    check_all("R7", "R7");

    // Random mix of plain and tracking updates
    p = '0;
    for (int n = 0; n < 40; n++) begin
      c = NB'($urandom);
      trk = 1'($urandom);
      if (($urandom % 4) == 0) p = NB'($urandom);
      apply(c, p, trk);
      check_all(trk ? "R4" : "R2", trk ? "R5" : "R3");
      p = c;
    end

    // R6: drive into the top limit, then a +2 tracking step at the limit
    do_clear(1'b0, '0);
    repeat (130) apply('1, '0, 1'b0);
    check_all("R6", "R6");
    apply('1, 8'b0000_0001, 1'b1);
    check_all("R6", "R6");
    // R6: pairs with bit 0 run down to the bottom limit
    repeat (260) apply(8'b0000_0001, '0, 1'b0);
    check_all("R6", "R6");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule